// File: doc/BRIEF.md
# Channel Hit Register with Trigger and Multiplicity

This block records which of a set of detector channels have fired since the last clear. Each channel has an asynchronous discriminator line. The block synchronizes every line, detects its rising edge, and latches the edge into a sticky per-channel hit bit. A channel whose inhibit input is high cannot set its bit. A dedicated clear input empties the whole register and does not touch the inhibit settings, which the block receives as inputs.

From the latched bits the block derives two outputs. The first is a trigger, which is the OR of all hit bits. The second is a multiplicity, which is a registered count of the bits that are set. The whole register is also presented in parallel, so that a control link can read out the hit pattern after an event.

Top module: `chan_hit_register`

## Requirements
- R1: After reset, all hit bits, the trigger and the multiplicity are 0.
- R2: A rising edge on a channel's discriminator line is applied at a falling clock edge. With default parameters, the channel's hit bit reads 1 after the third following rising clock edge and still reads 0 after the second.
- R3: A hit bit stays at 1 after its discriminator line falls, until a clear.
- R4: If a channel's inhibit is high when its edge reaches the register, the hit bit stays 0. An inhibit raised later does not remove a bit that is already set.
- R5: The trigger is 1 exactly when at least one hit bit is 1, in the same cycle.
- R6: The multiplicity equals the number of hit bits that were 1 one clock earlier. With 72 channels it is 7 bits wide.
- R7: A clear that is high at a rising clock edge makes all hit bits 0 after that edge, and the multiplicity 0 one edge later.
- R8: When a clear and a newly detected edge meet at the same clock edge, the clear wins. The hit bit stays 0 and that edge is not replayed later.
- R9: A discriminator line that is held high sets its bit only once. After a clear, the bit stays 0 until the line falls and rises again.
- R10: With every channel set and none inhibited, the multiplicity reads 72, which is the full channel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_in | input | 72 | Asynchronous discriminator lines, one per channel |
| inhibit_mask | input | 72 | Per-channel inhibit; 1 keeps the channel from setting its bit |
| hit_clear | input | 1 | Synchronous clear of all hit bits |
| hit_bits | output | 72 | Parallel view of the hit register, bit i for channel i |
| trig_or | output | 1 | OR of all hit bits |
| hit_count | output | 7 | Registered count of set hit bits |

## Verification
A corrupted hit bit appears on hit_bits after the very next clock edge. It reaches trig_or in the same cycle and reaches hit_count one edge later, so the three outputs must keep agreeing with one another. A synchronizer or edge detector that misbehaves shows up as a bit that lands one cycle early or late, or as a bit that reappears after a clear while its line is still held high. The bench watches both of those moments cycle by cycle. An inhibit or a clear that loses its priority leaves a 1 on hit_bits right after the edge in question.

// File: rtl/chr_pkg.sv
package chr_pkg;

  // Widest channel vector the helper functions accept.
  localparam int unsigned MAX_CH = 256;

  // Number of ones in a zero-extended channel vector.
  function automatic int unsigned count_ones(input logic [MAX_CH-1:0] vec);
    int unsigned acc;
    acc = 0;
    for (int i = 0; i < MAX_CH; i++) begin
      acc = acc + int'(vec[i]);
    end
    return acc;
  endfunction

  // Any bit set.
  function automatic logic any_set(input logic [MAX_CH-1:0] vec);
    return (vec != '0);
  endfunction

  // Next value of a sticky hit register. The clear has priority.
  function automatic logic [MAX_CH-1:0] next_hits(
    input logic [MAX_CH-1:0] cur,
    input logic [MAX_CH-1:0] edges,
    input logic [MAX_CH-1:0] block,
    input logic              clr
  );
    if (clr) return '0;
    return cur | (edges & ~block);
  endfunction

endpackage

// File: rtl/chr_sync_edge.sv
module chr_sync_edge #(
  parameter int unsigned NCH    = 72,
  parameter int unsigned STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] async_in,
  output logic [NCH-1:0] rise_vec
);

  // STAGES synchronizer flops, plus one flop that remembers the previous level.
  localparam int unsigned CHAIN = STAGES + 1;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN-2:0], async_in[ch]};
    end

    // The synchronized level is 1 now and was 0 one cycle earlier.
    assign rise_vec[ch] = chain_q[STAGES-1] & ~chain_q[STAGES];
  end

endmodule

// File: rtl/chr_hit_store.sv
module chr_hit_store #(
  parameter int unsigned NCH = 72
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rise_vec,
  input  logic [NCH-1:0] inhibit_mask,
  input  logic           hit_clear,
  output logic [NCH-1:0] hits_q
);

  localparam int unsigned WIDE = chr_pkg::MAX_CH;

  logic [WIDE-1:0] cur_w, edge_w, blk_w, nxt_w;

  always_comb begin
    cur_w            = '0;
    edge_w           = '0;
    blk_w            = '0;
    cur_w[NCH-1:0]   = hits_q;
    edge_w[NCH-1:0]  = rise_vec;
    blk_w[NCH-1:0]   = inhibit_mask;
    nxt_w            = chr_pkg::next_hits(cur_w, edge_w, blk_w, hit_clear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hits_q <= '0;
    else        hits_q <= nxt_w[NCH-1:0];
  end

endmodule

// File: rtl/chr_tally.sv
module chr_tally #(
  parameter int unsigned NCH   = 72,
  parameter int unsigned CNT_W = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   hits,
  output logic             trig,
  output logic [CNT_W-1:0] count_q
);

  localparam int unsigned WIDE = chr_pkg::MAX_CH;

  logic [WIDE-1:0]  hits_w;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    hits_w           = '0;
    hits_w[NCH-1:0]  = hits;
    trig             = chr_pkg::any_set(hits_w);
    count_d          = CNT_W'(chr_pkg::count_ones(hits_w));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

endmodule

// File: rtl/chan_hit_register.sv
module chan_hit_register #(
  parameter int unsigned NCH         = 72,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   disc_in,
  input  logic [NCH-1:0]   inhibit_mask,
  input  logic             hit_clear,
  output logic [NCH-1:0]   hit_bits,
  output logic             trig_or,
  output logic [CNT_W-1:0] hit_count
);

  // Rising-edge events after synchronization; also used by the checker.
  logic [NCH-1:0] rise_vec;

  chr_sync_edge #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (disc_in),
    .rise_vec (rise_vec)
  );

  chr_hit_store #(.NCH(NCH)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise_vec     (rise_vec),
    .inhibit_mask (inhibit_mask),
    .hit_clear    (hit_clear),
    .hits_q       (hit_bits)
  );

  chr_tally #(.NCH(NCH), .CNT_W(CNT_W)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .hits    (hit_bits),
    .trig    (trig_or),
    .count_q (hit_count)
  );

endmodule

// File: rtl/chan_hit_register_chk.sv
module chan_hit_register_chk #(
  parameter int unsigned NCH   = 72,
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   inhibit_mask,
  input logic             hit_clear,
  input logic [NCH-1:0]   rise_vec,
  input logic [NCH-1:0]   hit_bits,
  input logic             trig_or,
  input logic [CNT_W-1:0] hit_count
);

  AST_EDGE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_clear |=> ((($past(rise_vec) & ~$past(inhibit_mask)) & ~hit_bits) == '0)); // R2

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_clear |=> (($past(hit_bits) & ~hit_bits) == '0)); // R3

  AST_NO_INHIBITED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_bits & ~$past(hit_bits)) & ~($past(rise_vec) & ~$past(inhibit_mask))) == '0); // R4

  AST_TRIG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    trig_or == (hit_bits != '0)); // R5

  AST_COUNT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    32'(hit_count) == $countones($past(hit_bits))); // R6

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clear |=> (hit_bits == '0)); // R7

  AST_CLEAR_BEATS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clear |=> ((hit_bits & $past(rise_vec)) == '0)); // R8

endmodule

bind chan_hit_register chan_hit_register_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .inhibit_mask (inhibit_mask),
  .hit_clear    (hit_clear),
  .rise_vec     (rise_vec),
  .hit_bits     (hit_bits),
  .trig_or      (trig_or),
  .hit_count    (hit_count)
);

// File: tb/chan_hit_register_tb.sv
module chan_hit_register_tb;

  localparam int unsigned NCH   = 72;
  localparam int unsigned CNT_W = 7;
  localparam int unsigned NVEC  = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   disc_in = '0;
  logic [NCH-1:0]   inhibit_mask = '0;
  logic             hit_clear = 1'b0;
  logic [NCH-1:0]   hit_bits;
  logic             trig_or;
  logic [CNT_W-1:0] hit_count;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;   // 250 MHz

  chan_hit_register u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .disc_in      (disc_in),
    .inhibit_mask (inhibit_mask),
    .hit_clear    (hit_clear),
    .hit_bits     (hit_bits),
    .trig_or      (trig_or),
    .hit_count    (hit_count)
  );

  // Stimulus table: discriminator pattern and inhibit pattern.
  localparam logic [NCH-1:0] PAT [NVEC] = '{
    72'h00_0000_0000_0000_0001,
    72'h80_0000_0000_0000_0000,
    {72{1'b1}},
    72'hAA_AAAA_AAAA_AAAA_AAAA,
    72'h0F_F0F0_1234_5678_F0F0,
    {72{1'b1}}
  };
  localparam logic [NCH-1:0] INH [NVEC] = '{
    72'h00_0000_0000_0000_0000,
    72'h00_0000_0000_0000_0000,
    72'h00_0000_0000_0000_0000,
    72'h00_0000_0000_FFFF_0000,
    72'h03_3030_0000_0000_3030,
    {72{1'b1}}
  };

  function automatic int ones(input logic [NCH-1:0] v);
    int n = 0;
    foreach (v[i]) if (v[i] === 1'b1) n++;
    return n;
  endfunction

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    hit_clear = 1'b1;
    cyc(1);
    hit_clear = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [NCH-1:0] exp_bits;
    cyc(3);
    // R1: reset state
    chk("R1 bits", hit_bits, '0);
    chk("R1 trig", NCH'(trig_or), '0);
    chk("R1 count", NCH'(hit_count), '0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 bits after release", hit_bits, '0);

    // Table walk
    for (int k = 0; k < int'(NVEC); k++) begin
      exp_bits     = PAT[k] & ~INH[k];
      inhibit_mask = INH[k];
      disc_in      = PAT[k];
      cyc(2);
      chk("R2 not before third edge", hit_bits, '0);
      cyc(1);
      chk("R2 R4 bits set", hit_bits, exp_bits);
      chk("R5 trigger", NCH'(trig_or), NCH'(exp_bits != '0));
      cyc(1);
      chk("R6 R10 count", NCH'(hit_count), NCH'(ones(exp_bits)));
      disc_in = '0;
      cyc(4);
      chk("R3 bits sticky", hit_bits, exp_bits);
      do_clear();
      chk("R7 bits cleared", hit_bits, '0);
      cyc(1);
      chk("R7 count cleared", NCH'(hit_count), '0);
    end

    // R4: inhibit raised after the bit is set does not remove it
    inhibit_mask = '0;
    disc_in      = 72'h10;
    cyc(3);
    inhibit_mask = 72'h10;
    cyc(2);
    chk("R4 late inhibit keeps bit", hit_bits, 72'h10);
    disc_in = '0;
    inhibit_mask = '0;
    cyc(3);
    do_clear();

    // R8: clear at the same edge as the new edge
    disc_in = 72'h4;
    cyc(2);
    hit_clear = 1'b1;
    cyc(1);
    hit_clear = 1'b0;
    chk("R8 clear wins", hit_bits, '0);
    cyc(4);
    chk("R8 edge not replayed", hit_bits, '0);

    // R9: line still held high from the R8 step
    chk("R9 held line no reset", hit_bits, '0);
    disc_in = 72'h400;
    cyc(4);
    chk("R9 first set", hit_bits, 72'h400);
    do_clear();
    cyc(5);
    chk("R9 held high stays clear", hit_bits, '0);
    disc_in = '0;
    cyc(3);
    disc_in = 72'h400;
    cyc(3);
    chk("R9 new rise sets again", hit_bits, 72'h400);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule